// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Unit

This unit sits beside the sequencer of a small 16-bit processor core and chooses, at each instruction boundary, which pending interrupt source is taken next. It sees divide-error and coprocessor-segment-overrun exceptions, software INT requests carrying any 8-bit type, a non-maskable request, a maskable request whose 8-bit type is supplied by an external interrupt controller, and the single-step condition that follows from the trap flag. It also sees strobes for IRET, for setting IF and for writing the trap flag.

When a source wins, the unit emits a one-cycle take pulse. The pulse carries the chosen type, the byte address of that type's vector-table entry, an acknowledge for the external controller when the maskable request won, and a restart flag telling the sequencer to save the address of the faulting instruction. Each table entry is four bytes: a 16-bit offset followed by a 16-bit selector.

Taking any interrupt clears IF. Taking the non-maskable request also sets a block latch that ignores further non-maskable, maskable, segment-overrun and single-step requests until IRET or reset. Instruction fetch, table reads and stack pushes belong to the core around it.

Top module: `intr_vector_unit`

## Requirements
- R1: After reset, take, intr_ack and restart are 0, and if_flag, tf_flag and nmi_blocked are all 0.
- R2: On a take, take_addr equals take_type multiplied by 4 (type in bits 9:2, bits 1:0 zero).
- R3: A taken non-maskable request yields type 0x02 whatever intr_type holds, and sets nmi_blocked in the same cycle as the take pulse.
- R4: While tf_flag is 1 and nothing else wins, every boundary yields a single-step take of type 0x01; tf_flag follows tf_val on a tf_wr strobe.
- R5: Priority from highest to lowest is divide error, segment overrun, software INT, non-maskable, maskable, single step.
- R6: While nmi_blocked is 1, non-maskable, maskable, segment-overrun and single-step requests produce no take; divide error and software INT are still taken.
- R7: Every take clears if_flag. An iret strobe sets if_flag and clears nmi_blocked, and an sti strobe sets if_flag. If a take coincides with either strobe, the take wins for if_flag.
- R8: The maskable request is ignored while if_flag is 0. When it wins, take_type equals the intr_type sampled at the boundary and intr_ack pulses with take; intr_ack is 0 for every other source.
- R9: A software INT is taken with its own swi_type over the full range 0x00 to 0xFF.
- R10: A divide error takes type 0x00 and a segment overrun takes type 0x09, both with restart at 1; every other source takes with restart at 0.
- R11: Requests are sampled only in a cycle with boundary at 1. The take pulse is registered, appears in the following cycle and lasts one cycle for a single boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary: requests are sampled in this cycle |
| div_err | input | 1 | Divide-error exception |
| cso_req | input | 1 | Coprocessor segment-overrun request |
| swi_req | input | 1 | Software INT request |
| swi_type | input | 8 | Type of the software INT |
| nmi_req | input | 1 | Non-maskable request |
| intr_req | input | 1 | Maskable request |
| intr_type | input | 8 | Type supplied by the external controller |
| iret | input | 1 | IRET executed |
| sti | input | 1 | Set IF |
| tf_wr | input | 1 | Write trap flag |
| tf_val | input | 1 | Value written to the trap flag |
| take | output | 1 | One-cycle interrupt taken pulse |
| take_type | output | 8 | Type of the interrupt taken |
| take_addr | output | 10 | Byte address of the vector-table entry |
| intr_ack | output | 1 | Acknowledge to the external controller |
| restart | output | 1 | Saved return address must be the faulting instruction |
| if_flag | output | 1 | Interrupt enable flag |
| tf_flag | output | 1 | Trap flag |
| nmi_blocked | output | 1 | Block latch set by a taken non-maskable request |

## Verification
The selection logic is driven with a single source at a time, then with every source raised at once and removed one at a time from the top. This separates a wrong priority order from a wrong type or address. Software types at both ends of the range and in the middle show the type path is not truncated. The maskable request is tried with IF clear and set, and a non-maskable type is paired with a non-zero intr_type to show the fixed vector is used. With the block latch set, each blockable source is raised and the exempt exceptions still go through, so over-blocking and under-blocking each show up. Requests raised without a boundary must leave take low.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;
   typedef enum logic [2:0] {
      SRC_NONE = 3'd0,
      SRC_DIV  = 3'd1,
      SRC_CSO  = 3'd2,
      SRC_SWI  = 3'd3,
      SRC_NMI  = 3'd4,
      SRC_INTR = 3'd5,
      SRC_STEP = 3'd6
   } intr_src_e;
endpackage

// File: rtl/intr_pick.sv
module intr_pick
   import intr_arb_pkg::*;
#(
   parameter int unsigned        TYPE_W    = 8,
   parameter bit                 STEP_EN   = 1'b1,
   parameter logic [TYPE_W-1:0]  DIV_TYPE  = 'h00,
   parameter logic [TYPE_W-1:0]  CSO_TYPE  = 'h09,
   parameter logic [TYPE_W-1:0]  NMI_TYPE  = 'h02,
   parameter logic [TYPE_W-1:0]  STEP_TYPE = 'h01
) (
   input  logic              boundary,
   input  logic              div_err,
   input  logic              cso_req,
   input  logic              swi_req,
   input  logic [TYPE_W-1:0] swi_type,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [TYPE_W-1:0] intr_type,
   input  logic              if_q,
   input  logic              tf_q,
   input  logic              blk_q,
   output logic              pick_vld,
   output intr_src_e         pick_src,
   output logic [TYPE_W-1:0] pick_type
);
   logic step_ok;

   generate
      if (STEP_EN) begin : g_step
         assign step_ok = tf_q & ~blk_q;
      end else begin : g_nostep
         logic unused_tf;
         assign unused_tf = tf_q;
         assign step_ok   = 1'b0;
      end
   endgenerate

   always_comb begin
      pick_src  = SRC_NONE;
      pick_type = '0;
      if (boundary) begin
         if (div_err) begin
            pick_src  = SRC_DIV;
            pick_type = DIV_TYPE;
         end else if (cso_req && !blk_q) begin
            pick_src  = SRC_CSO;
            pick_type = CSO_TYPE;
         end else if (swi_req) begin
            pick_src  = SRC_SWI;
            pick_type = swi_type;
         end else if (nmi_req && !blk_q) begin
            pick_src  = SRC_NMI;
            pick_type = NMI_TYPE;
         end else if (intr_req && if_q && !blk_q) begin
            pick_src  = SRC_INTR;
            pick_type = intr_type;
         end else if (step_ok) begin
            pick_src  = SRC_STEP;
            pick_type = STEP_TYPE;
         end
      end
      pick_vld = (pick_src != SRC_NONE);
   end
endmodule

// File: rtl/intr_flags.sv
module intr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic accept_nmi,
   input  logic iret,
   input  logic sti,
   input  logic tf_wr,
   input  logic tf_val,
   output logic if_q,
   output logic tf_q,
   output logic blk_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         if_q  <= 1'b0;
         tf_q  <= 1'b0;
         blk_q <= 1'b0;
      end else begin
         if (accept)           if_q <= 1'b0;
         else if (iret || sti) if_q <= 1'b1;

         if (accept_nmi)       blk_q <= 1'b1;
         else if (iret)        blk_q <= 1'b0;

         if (tf_wr)            tf_q <= tf_val;
      end
   end
endmodule

// File: rtl/intr_vec_reg.sv
module intr_vec_reg
   import intr_arb_pkg::*;
#(
   parameter int unsigned TYPE_W      = 8,
   parameter int unsigned ENTRY_BYTES = 4,
   localparam int unsigned SH         = $clog2(ENTRY_BYTES),
   localparam int unsigned ADDR_W     = TYPE_W + SH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pick_vld,
   input  intr_src_e         pick_src,
   input  logic [TYPE_W-1:0] pick_type,
   output logic              take,
   output logic [TYPE_W-1:0] take_type,
   output logic [ADDR_W-1:0] take_addr,
   output logic              intr_ack,
   output logic              restart
);
   logic [ADDR_W-1:0] addr_c;

   generate
      if ((1 << SH) == ENTRY_BYTES) begin : g_shift
         assign addr_c = ADDR_W'(pick_type) << SH;
      end else begin : g_mult
         assign addr_c = ADDR_W'(pick_type) * ADDR_W'(ENTRY_BYTES);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take      <= 1'b0;
         take_type <= '0;
         take_addr <= '0;
         intr_ack  <= 1'b0;
         restart   <= 1'b0;
      end else begin
         take     <= pick_vld;
         intr_ack <= (pick_src == SRC_INTR);
         restart  <= (pick_src == SRC_DIV) || (pick_src == SRC_CSO);
         if (pick_vld) begin
            take_type <= pick_type;
            take_addr <= addr_c;
         end
      end
   end
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
   import intr_arb_pkg::*;
#(
   parameter int unsigned       TYPE_W      = 8,
   parameter int unsigned       ENTRY_BYTES = 4,
   parameter bit                STEP_EN     = 1'b1,
   parameter logic [TYPE_W-1:0] DIV_TYPE    = 'h00,
   parameter logic [TYPE_W-1:0] CSO_TYPE    = 'h09,
   parameter logic [TYPE_W-1:0] NMI_TYPE    = 'h02,
   parameter logic [TYPE_W-1:0] STEP_TYPE   = 'h01,
   localparam int unsigned      ADDR_W      = TYPE_W + $clog2(ENTRY_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              div_err,
   input  logic              cso_req,
   input  logic              swi_req,
   input  logic [TYPE_W-1:0] swi_type,
   input  logic              nmi_req,
   input  logic              intr_req,
   input  logic [TYPE_W-1:0] intr_type,
   input  logic              iret,
   input  logic              sti,
   input  logic              tf_wr,
   input  logic              tf_val,
   output logic              take,
   output logic [TYPE_W-1:0] take_type,
   output logic [ADDR_W-1:0] take_addr,
   output logic              intr_ack,
   output logic              restart,
   output logic              if_flag,
   output logic              tf_flag,
   output logic              nmi_blocked
);
   generate
      if (TYPE_W < 2 || TYPE_W > 16) begin : g_bad_type_w
         $error("TYPE_W must be within 2..16");
      end
      if (ENTRY_BYTES < 1) begin : g_bad_entry
         $error("ENTRY_BYTES must be at least 1");
      end
   endgenerate

   logic              pick_vld;
   intr_src_e         pick_src;
   logic [TYPE_W-1:0] pick_type;

   intr_pick #(
      .TYPE_W(TYPE_W), .STEP_EN(STEP_EN), .DIV_TYPE(DIV_TYPE),
      .CSO_TYPE(CSO_TYPE), .NMI_TYPE(NMI_TYPE), .STEP_TYPE(STEP_TYPE)
   ) u_pick (
      .boundary(boundary), .div_err(div_err), .cso_req(cso_req),
      .swi_req(swi_req), .swi_type(swi_type), .nmi_req(nmi_req),
      .intr_req(intr_req), .intr_type(intr_type), .if_q(if_flag),
      .tf_q(tf_flag), .blk_q(nmi_blocked), .pick_vld(pick_vld),
      .pick_src(pick_src), .pick_type(pick_type)
   );

   intr_flags u_flags (
      .clk(clk), .rst_n(rst_n), .accept(pick_vld),
      .accept_nmi(pick_src == SRC_NMI), .iret(iret), .sti(sti),
      .tf_wr(tf_wr), .tf_val(tf_val), .if_q(if_flag), .tf_q(tf_flag),
      .blk_q(nmi_blocked)
   );

   intr_vec_reg #(
      .TYPE_W(TYPE_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .pick_vld(pick_vld), .pick_src(pick_src),
      .pick_type(pick_type), .take(take), .take_type(take_type),
      .take_addr(take_addr), .intr_ack(intr_ack), .restart(restart)
   );
endmodule

// File: rtl/intr_vector_unit_chk.sv
module intr_vector_unit_chk #(
   parameter int unsigned       TYPE_W   = 8,
   parameter logic [TYPE_W-1:0] DIV_TYPE = 'h00,
   parameter logic [TYPE_W-1:0] CSO_TYPE = 'h09,
   parameter logic [TYPE_W-1:0] NMI_TYPE = 'h02
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boundary,
   input logic              iret,
   input logic              sti,
   input logic [TYPE_W-1:0] intr_type,
   input logic              take,
   input logic [TYPE_W-1:0] take_type,
   input logic              intr_ack,
   input logic              restart,
   input logic              if_flag,
   input logic              nmi_blocked
);
   // R11
   take_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(boundary));

   // R8
   ack_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intr_ack |-> take && $past(if_flag) && take_type == $past(intr_type));

   // R7
   take_clears_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !if_flag);

   // R7
   if_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(if_flag) |-> $past(iret) || $past(sti));

   // R3
   block_rise_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_blocked) |-> take && take_type == NMI_TYPE);

   // R6
   blocked_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && $past(nmi_blocked) |-> !intr_ack);

   // R10
   restart_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && restart |-> take_type == DIV_TYPE || take_type == CSO_TYPE);
endmodule

bind intr_vector_unit intr_vector_unit_chk #(
   .TYPE_W(TYPE_W), .DIV_TYPE(DIV_TYPE), .CSO_TYPE(CSO_TYPE), .NMI_TYPE(NMI_TYPE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .boundary(boundary), .iret(iret), .sti(sti),
   .intr_type(intr_type), .take(take), .take_type(take_type),
   .intr_ack(intr_ack), .restart(restart), .if_flag(if_flag),
   .nmi_blocked(nmi_blocked)
);

// File: tb/test_intr_vector_unit.sv
module test_intr_vector_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boundary = 0, div_err = 0, cso_req = 0, swi_req = 0;
   logic [7:0] swi_type = 0, intr_type = 0;
   logic       nmi_req = 0, intr_req = 0, iret = 0, sti = 0, tf_wr = 0, tf_val = 0;
   logic       take, intr_ack, restart, if_flag, tf_flag, nmi_blocked;
   logic [7:0] take_type;
   logic [9:0] take_addr;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   intr_vector_unit i_intr_vector_unit (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .div_err(div_err),
      .cso_req(cso_req), .swi_req(swi_req), .swi_type(swi_type),
      .nmi_req(nmi_req), .intr_req(intr_req), .intr_type(intr_type),
      .iret(iret), .sti(sti), .tf_wr(tf_wr), .tf_val(tf_val),
      .take(take), .take_type(take_type), .take_addr(take_addr),
      .intr_ack(intr_ack), .restart(restart), .if_flag(if_flag),
      .tf_flag(tf_flag), .nmi_blocked(nmi_blocked)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // raise boundary for one cycle with the requests already set, then drop all requests
   task automatic bnd();
      boundary = 1'b1;
      @(negedge clk);
      boundary = 0; div_err = 0; cso_req = 0; swi_req = 0; nmi_req = 0; intr_req = 0;
   endtask

   task automatic pulse_iret();
      iret = 1'b1; @(negedge clk); iret = 1'b0;
   endtask

   task automatic pulse_sti();
      sti = 1'b1; @(negedge clk); sti = 1'b0;
   endtask

   task automatic write_tf(input logic v);
      tf_wr = 1'b1; tf_val = v; @(negedge clk); tf_wr = 1'b0;
   endtask

   task automatic expect_take(input string tag, input logic [7:0] t, input logic ack, input logic rs);
      chk(take == 1'b1, {tag, " take"}, take, 1);
      chk(take_type == t, {tag, " type"}, take_type, t);
      chk(take_addr == {t, 2'b00}, {tag, " R2 addr"}, take_addr, {t, 2'b00});
      chk(intr_ack == ack, {tag, " ack"}, intr_ack, ack);
      chk(restart == rs, {tag, " restart"}, restart, rs);
      chk(if_flag == 1'b0, {tag, " R7 if cleared"}, if_flag, 0);
   endtask

   task automatic t_reset();
      chk(take == 0 && intr_ack == 0 && restart == 0, "R1 outputs", {take, intr_ack, restart}, 0);
      chk(if_flag == 0 && tf_flag == 0 && nmi_blocked == 0, "R1 flags",
          {if_flag, tf_flag, nmi_blocked}, 0);
   endtask

   task automatic t_no_boundary();
      div_err = 1; nmi_req = 1; swi_req = 1;
      @(negedge clk);
      chk(take == 0, "R11 no boundary no take", take, 0);
      div_err = 0; nmi_req = 0; swi_req = 0;
      @(negedge clk);
   endtask

   task automatic t_div();
      div_err = 1; bnd();
      expect_take("R10 div", 8'h00, 0, 1);
      @(negedge clk);
      chk(take == 0, "R11 single cycle pulse", take, 0);
   endtask

   task automatic t_swi();
      foreach (swi_vals[i]) begin
         swi_req = 1; swi_type = swi_vals[i]; bnd();
         expect_take("R9 swi", swi_vals[i], 0, 0);
      end
   endtask
   logic [7:0] swi_vals [3] = '{8'h00, 8'h5A, 8'hFF};

   task automatic t_intr();
      intr_req = 1; intr_type = 8'h37; bnd();
      chk(take == 0, "R8 masked while IF clear", take, 0);
      pulse_sti();
      chk(if_flag == 1, "R7 sti sets IF", if_flag, 1);
      intr_req = 1; intr_type = 8'h37; bnd();
      expect_take("R8 intr", 8'h37, 1, 0);
   endtask

   task automatic t_nmi_block();
      nmi_req = 1; intr_type = 8'hC4; bnd();
      expect_take("R3 nmi", 8'h02, 0, 0);
      chk(nmi_blocked == 1, "R3 block set", nmi_blocked, 1);
      nmi_req = 1; bnd();
      chk(take == 0, "R6 second nmi ignored", take, 0);
      cso_req = 1; bnd();
      chk(take == 0, "R6 cso ignored", take, 0);
      pulse_sti();
      intr_req = 1; intr_type = 8'h11; bnd();
      chk(take == 0, "R6 intr ignored", take, 0);
      chk(if_flag == 1, "R6 IF untouched by blocked intr", if_flag, 1);
      write_tf(1);
      bnd();
      chk(take == 0, "R6 step ignored", take, 0);
      write_tf(0);
      div_err = 1; bnd();
      expect_take("R6 div while blocked", 8'h00, 0, 1);
      swi_req = 1; swi_type = 8'h21; bnd();
      expect_take("R6 swi while blocked", 8'h21, 0, 0);
      pulse_iret();
      chk(nmi_blocked == 0, "R7 iret clears block", nmi_blocked, 0);
      chk(if_flag == 1, "R7 iret sets IF", if_flag, 1);
      nmi_req = 1; bnd();
      expect_take("R3 nmi after iret", 8'h02, 0, 0);
      pulse_iret();
   endtask

   task automatic rung(input int lvl);
      pulse_iret();
      div_err = (lvl <= 0); cso_req = (lvl <= 1); swi_req = (lvl <= 2);
      nmi_req = (lvl <= 3); intr_req = (lvl <= 4);
      swi_type = 8'h77; intr_type = 8'h40;
      bnd();
   endtask

   task automatic t_priority();
      write_tf(1);
      chk(tf_flag == 1, "R4 tf write", tf_flag, 1);
      rung(0); expect_take("R5 div first", 8'h00, 0, 1);
      rung(1); expect_take("R5 cso second", 8'h09, 0, 1);
      rung(2); expect_take("R5 swi third", 8'h77, 0, 0);
      rung(3); expect_take("R5 nmi fourth", 8'h02, 0, 0);
      rung(4); expect_take("R5 intr fifth", 8'h40, 1, 0);
      rung(5); expect_take("R4 step last", 8'h01, 0, 0);
      bnd();   expect_take("R4 step each boundary", 8'h01, 0, 0);
      write_tf(0);
      bnd();
      chk(take == 0, "R4 no step with tf clear", take, 0);
      pulse_iret();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_boundary();
      t_div();
      t_swi();
      t_intr();
      t_nmi_block();
      t_priority();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule